// File: doc/BRIEF.md
# Dual-Mask Level Interrupt Combiner

The block collects 32 level-sensitive interrupt lines and reduces them to two request outputs: a normal request and a fast request. Each output has its own 32-bit enable mask. A line asserts an output only while the line is high and its bit in that output's mask is set. Software changes a mask only through a pair of registers. One register of the pair sets the mask bits where the written word has ones, and the other clears them, so no read-modify-write is needed.

Line 0 also carries a software-owned request bit, which is ORed with the hardware level on that line. The register port is a plain 32-bit word port: one word offset, a write strobe and a combinational read. The block does not vector and does not prioritise. It does not detect edges either: it passes levels through. Several instances can be chained by wiring the normal output of one instance to a source input of another. That input is handled like any other line.

Top module: `dual_mask_intc`

## Requirements
- R1: During and after reset, both enable masks and the software request bit are zero, and both outputs are low.
- R2: Reading word offset 1 or 9 returns the raw level: the 32 source inputs, with bit 0 ORed with the software request bit.
- R3: Reading word offset 0 returns the raw level ANDed with the normal mask. Reading offset 8 returns the raw level ANDed with the fast mask.
- R4: Writing offset 2 ORs the write data into the normal mask. Reading offset 2 returns the normal mask.
- R5: Writing offset 3 clears the normal-mask bits where the write data has ones. Reading offset 3 returns zero.
- R6: Offsets 10 and 11 set and clear the fast mask in the same way. Reading offset 10 returns the fast mask, and reading offset 11 returns zero.
- R7: A write to offset 4 with data bit 0 set raises the software request bit. A write to offset 5 with data bit 0 set lowers it. Data bits 31..1 of these writes are ignored. Reading offset 4 or 5 returns zero.
- R8: The normal output is registered. After each clock edge it is high exactly when the raw level ANDed with the normal mask was nonzero just before that edge.
- R9: The fast output follows the same rule as R8, using the fast mask.
- R10: Writes to offsets 0, 1, 8, 9 and to unmapped offsets change no state. Reads of unmapped offsets (6, 7, 12 to 15) return zero.
- R11: The two masks are independent: a set or clear on one mask never changes the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| src_lvl | input | 32 | Raw source levels |
| irq_o | output | 1 | Normal request output |
| fiq_o | output | 1 | Fast request output |

## Verification
A wrong mask bit shows up in two places. It appears on the read of the mask offset in the same cycle, and it changes the output one clock after a matching source level is applied. A software request bit that is stuck or lost shows in raw bit 0 at once. It reaches the outputs one edge later, once a mask enables line 0. The bench compares the read data and both outputs against a behavioural model every cycle, so a corrupted state is reported within one cycle of becoming observable.

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  input  logic [W-1:0]      src_lvl,
  output logic              irq_o,
  output logic              fiq_o
);

  localparam logic [ADDR_W-1:0] OFF_N_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_N_RAW  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFF_N_SET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_N_CLR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFF_SW_SET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_SW_CLR = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] OFF_F_STAT = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFF_F_RAW  = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] OFF_F_SET  = ADDR_W'(10);
  localparam logic [ADDR_W-1:0] OFF_F_CLR  = ADDR_W'(11);

  logic [W-1:0] irq_mask, fiq_mask;
  logic         sw_req;
  logic [W-1:0] raw;

  assign raw = src_lvl | {{(W-1){1'b0}}, sw_req};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_mask <= '0;
      fiq_mask <= '0;
      sw_req   <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        OFF_N_SET:  irq_mask <= irq_mask | reg_wdata;
        OFF_N_CLR:  irq_mask <= irq_mask & ~reg_wdata;
        OFF_F_SET:  fiq_mask <= fiq_mask | reg_wdata;
        OFF_F_CLR:  fiq_mask <= fiq_mask & ~reg_wdata;
        OFF_SW_SET: if (reg_wdata[0]) sw_req <= 1'b1;
        OFF_SW_CLR: if (reg_wdata[0]) sw_req <= 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |(raw & irq_mask);
      fiq_o <= |(raw & fiq_mask);
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_N_STAT: reg_rdata = raw & irq_mask;
      OFF_N_RAW,
      OFF_F_RAW:  reg_rdata = raw;
      OFF_N_SET:  reg_rdata = irq_mask;
      OFF_F_STAT: reg_rdata = raw & fiq_mask;
      OFF_F_SET:  reg_rdata = fiq_mask;
      default:    reg_rdata = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && !fiq_o && irq_mask == '0 && fiq_mask == '0 && !sw_req)); // R1

  AST_NSET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_N_SET) |=> ((irq_mask & $past(reg_wdata)) == $past(reg_wdata))); // R4

  AST_NCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_N_CLR) |=> ((irq_mask & $past(reg_wdata)) == '0)); // R5

  AST_FSET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_F_SET) |=> ((fiq_mask & $past(reg_wdata)) == $past(reg_wdata))); // R6

  AST_FCLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_F_CLR) |=> ((fiq_mask & $past(reg_wdata)) == '0)); // R6

  AST_SW_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_SW_SET && reg_wdata[0]) |=> sw_req); // R7

  AST_SW_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == OFF_SW_CLR && reg_wdata[0]) |=> !sw_req); // R7

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |=> !irq_o); // R8

  AST_FIQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_mask == '0) |=> !fiq_o); // R9

  AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == OFF_N_STAT || reg_addr == OFF_N_RAW ||
                reg_addr == OFF_F_STAT || reg_addr == OFF_F_RAW))
    |=> ($stable(irq_mask) && $stable(fiq_mask) && $stable(sw_req))); // R10

  AST_NMASK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == OFF_N_SET || reg_addr == OFF_N_CLR)) |=> $stable(fiq_mask)); // R11

endmodule

// File: tb/dual_mask_intc_tb.sv
module dual_mask_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [31:0] src_lvl;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_nmask, m_fmask;
  bit          m_sw, m_irq, m_fiq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mask_intc u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_lvl(src_lvl),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] m_raw(logic [31:0] s);
    return s | {31'd0, m_sw};
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] a, logic [31:0] s);
    case (a)
      4'd0:  return m_raw(s) & m_nmask;
      4'd1:  return m_raw(s);
      4'd2:  return m_nmask;
      4'd8:  return m_raw(s) & m_fmask;
      4'd9:  return m_raw(s);
      4'd10: return m_fmask;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0, 4'd8: return "R3";
      4'd1, 4'd9: return "R2";
      4'd2:       return "R4";
      4'd3:       return "R5";
      4'd10, 4'd11: return "R6";
      4'd4, 4'd5: return "R7";
      default:    return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(bit we, logic [3:0] a, logic [31:0] wd, logic [31:0] s);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = wd; src_lvl = s;
    #1;
    check(tag_of(a), reg_rdata, m_read(a, s));
    check("R8", {31'd0, irq_o}, {31'd0, m_irq});
    check("R9", {31'd0, fiq_o}, {31'd0, m_fiq});
    m_irq = |(m_raw(s) & m_nmask);
    m_fiq = |(m_raw(s) & m_fmask);
    if (we) begin
      case (a)
        4'd2:  m_nmask |= wd;
        4'd3:  m_nmask &= ~wd;
        4'd10: m_fmask |= wd;
        4'd11: m_fmask &= ~wd;
        4'd4:  if (wd[0]) m_sw = 1;
        4'd5:  if (wd[0]) m_sw = 0;
        default: ;
      endcase
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0; src_lvl = 32'hFFFF_FFFF;
    m_nmask = 0; m_fmask = 0; m_sw = 0; m_irq = 0; m_fiq = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", {31'd0, irq_o}, 32'd0);
    check("R1", {31'd0, fiq_o}, 32'd0);
    reg_addr = 4'd2; #1; check("R1", reg_rdata, 32'd0);
    reg_addr = 4'd10; #1; check("R1", reg_rdata, 32'd0);
    reg_addr = 4'd1; src_lvl = 0; #1; check("R1", reg_rdata, 32'd0);
    rst_n = 1;

    step(0, 4'd1, 0, 32'hA5A5_0F0F);
    step(0, 4'd0, 0, 32'hA5A5_0F0F);
    step(1, 4'd2, 32'h0000_00F0, 32'h0000_0010);
    step(0, 4'd0, 0, 32'h0000_0010);
    step(0, 4'd8, 0, 32'h0000_0010);   // R11: fast mask untouched
    step(1, 4'd10, 32'h8000_0001, 32'h0);
    step(1, 4'd2, 32'h0000_0F00, 32'h0);
    step(0, 4'd2, 0, 32'h8000_0000);
    step(1, 4'd3, 32'h0000_0030, 32'h8000_0000);
    step(0, 4'd3, 0, 32'h0000_0020);
    step(0, 4'd2, 0, 32'h0000_0020);
    step(1, 4'd4, 32'h0000_0000, 32'h0);  // R7: bit0 clear ignored
    step(0, 4'd1, 0, 32'h0);
    step(1, 4'd4, 32'hFFFF_FFFE, 32'h0);
    step(0, 4'd1, 0, 32'h0);
    step(1, 4'd4, 32'h0000_0001, 32'h0);
    step(0, 4'd9, 0, 32'h0);
    step(0, 4'd8, 0, 32'h0);
    step(0, 4'd4, 0, 32'h0);
    step(1, 4'd5, 32'h0000_0001, 32'h0);
    step(0, 4'd5, 0, 32'h0);
    step(1, 4'd0, 32'hFFFF_FFFF, 32'h1);  // R10
    step(1, 4'd1, 32'hFFFF_FFFF, 32'h1);
    step(1, 4'd8, 32'hFFFF_FFFF, 32'h1);
    step(1, 4'd9, 32'hFFFF_FFFF, 32'h1);
    step(1, 4'd7, 32'hFFFF_FFFF, 32'h1);
    step(1, 4'd14, 32'hFFFF_FFFF, 32'h1);
    step(0, 4'd2, 0, 32'h1);
    step(0, 4'd10, 0, 32'h1);
    step(0, 4'd6, 0, 32'hFFFF_FFFF);
    step(0, 4'd12, 0, 32'hFFFF_FFFF);
    step(0, 4'd15, 0, 32'hFFFF_FFFF);
    step(1, 4'd11, 32'hFFFF_FFFF, 32'h1);
    step(0, 4'd11, 0, 32'h1);
    step(0, 4'd2, 0, 32'h1);

    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [31:0] wd, s;
      a  = 4'($urandom_range(0, 15));
      wd = $urandom;
      s  = $urandom & $urandom;
      step(1'($urandom_range(0, 1)), a, wd, s);
    end
    step(0, 4'd0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule